// File: doc/BRIEF.md
# Byte-Windowed Instruction RAM Loader

This block lets a host with an 8-bit register interface fill and inspect a 32-bit-wide instruction memory of 512 words. The host sets a 9-bit word address through a low and a high address register. It then streams bytes through one data register. Four successive writes, least significant byte first, make up one word. The fourth byte commits the whole word to the RAM in a single cycle and steps the word address. Reads of the data register walk the same byte lanes and follow the same stepping rule.

A small control register gates the data register through a load-enable bit. The same register provides a reset bit that clears the word address and a single-step bit. Its three bits also drive outputs toward the processor that will run the program. That processor is outside this block.

Top module: `iram_byte_loader`

## Requirements
- R1: After reset the control register reads 0x00, both address registers read 0x00, and the three control outputs are 0.
- R2: The register select codes are 0 control, 1 data, 2 address low, 3 address high. In the control register, bit 0 is load enable, bit 1 is sequencer reset and bit 2 is single step. All three bits read back and drive load_en_o, seq_rst_o and step_o.
- R3: With load enable set, data-register writes fill byte lanes 0, 1, 2 and then 3. The word is committed to the RAM at the current address on the lane-3 write, and the word address increments by one only then.
- R4: In the address high register only bit 0 is stored, as word address bit 8. It reads back with bits 7:1 as zero.
- R5: A write to either address register returns the byte lane to 0.
- R6: A control write with bit 1 set clears both the word address and the byte lane.
- R7: With load enable set, a data-register read returns the current lane of the addressed word in the same cycle. It advances the lane and the address by the same rule as R3.
- R8: With load enable clear, data-register accesses have no effect. Writes change neither the RAM, the lane nor the address, and reads return 0x00.
- R9: Stepping past word 511 wraps the address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access strobe, one access per cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_reg | input | 2 | Register select |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Read data, valid in the cycle of the access |
| load_en_o | output | 1 | Control bit 0 |
| seq_rst_o | output | 1 | Control bit 1 |
| step_o | output | 1 | Control bit 2 |

## Verification
The assertions assume that the host makes at most one access per cycle and holds its inputs stable around the clock edge. The bench keeps to this by driving each access on the falling edge, sampling the read data before the next rising edge, and then dropping the strobe. The assertions also assume that no address write and data access occur in the same cycle. This holds because a single select code names the register.

// File: rtl/iram_byte_loader.sv
module iram_byte_loader #(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_sel,
  input  logic       hst_wr,
  input  logic [1:0] hst_reg,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata,
  output logic       load_en_o,
  output logic       seq_rst_o,
  output logic       step_o
);
  localparam int WORD_W = BYTES * 8;
  localparam int IDX_W  = $clog2(BYTES);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

  localparam logic [1:0] REG_CTL = 2'd0;
  localparam logic [1:0] REG_DAT = 2'd1;
  localparam logic [1:0] REG_ALO = 2'd2;
  localparam logic [1:0] REG_AHI = 2'd3;

  logic [2:0]        ctl;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        stage [BYTES-1];
  logic [WORD_W-1:0] ram   [DEPTH];
  logic [WORD_W-1:0] word_rd, word_wr;

  wire dat_acc = hst_sel && hst_reg == REG_DAT && ctl[0];
  wire dat_wr  = dat_acc && hst_wr;
  wire ctl_wr  = hst_sel && hst_wr && hst_reg == REG_CTL;
  wire alo_wr  = hst_sel && hst_wr && hst_reg == REG_ALO;
  wire ahi_wr  = hst_sel && hst_wr && hst_reg == REG_AHI;

  assign load_en_o = ctl[0];
  assign seq_rst_o = ctl[1];
  assign step_o    = ctl[2];
  assign word_rd   = ram[addr];

  always_comb begin
    word_wr = '0;
    for (int i = 0; i < BYTES - 1; i++) word_wr[i*8 +: 8] = stage[i];
    word_wr[WORD_W-1 -: 8] = hst_wdata;
  end

  always_comb begin
    case (hst_reg)
      REG_CTL: hst_rdata = {5'b0, ctl};
      REG_DAT: hst_rdata = ctl[0] ? word_rd[{idx, 3'b000} +: 8] : 8'h00;
      REG_ALO: hst_rdata = addr[7:0];
      default: hst_rdata = 8'(addr[ADDR_W-1:8]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      addr <= '0;
      idx  <= '0;
    end else if (ctl_wr) begin
      ctl <= hst_wdata[2:0];
      if (hst_wdata[1]) begin
        addr <= '0;
        idx  <= '0;
      end
    end else if (alo_wr) begin
      addr[7:0] <= hst_wdata;
      idx       <= '0;
    end else if (ahi_wr) begin
      addr[ADDR_W-1:8] <= hst_wdata[HI_W-1:0];
      idx              <= '0;
    end else if (dat_acc) begin
      if (idx == LAST) begin
        idx  <= '0;
        addr <= addr + ADDR_W'(1);
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dat_wr && idx != LAST) stage[idx] <= hst_wdata;
  end

  always_ff @(posedge clk) begin
    if (dat_wr && idx == LAST) ram[addr] <= word_wr;
  end

  assert_commit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && idx == LAST) |=> (idx == '0 && addr == $past(addr) + ADDR_W'(1)));

  assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && idx != LAST) |=> ($stable(addr) && idx == $past(idx) + IDX_W'(1)));

  assert_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && hst_reg == REG_DAT && !ctl[0]) |=> ($stable(addr) && $stable(idx)));

  assert_addr_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ahi_wr |=> (addr[8] == $past(hst_wdata[0]) && idx == '0));

  assert_lane_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alo_wr |=> (idx == '0 && addr[7:0] == $past(hst_wdata)));

  assert_ctl_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && hst_wdata[1]) |=> (addr == '0 && idx == '0 && seq_rst_o));
endmodule

// File: tb/iram_byte_loader_bench.sv
module iram_byte_loader_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       hst_sel = 0, hst_wr = 0;
  logic [1:0] hst_reg = 0;
  logic [7:0] hst_wdata = 0;
  logic [7:0] hst_rdata;
  logic       load_en_o, seq_rst_o, step_o;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iram_byte_loader u_iram_byte_loader (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
    .hst_reg(hst_reg), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .load_en_o(load_en_o), .seq_rst_o(seq_rst_o), .step_o(step_o));

  // {check, write, reg, wdata, expected}; reg 0 ctl, 1 data, 2 addr lo, 3 addr hi
  localparam int NV = 24;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 8'h01, 8'h00},
    {1'b0, 1'b1, 2'd2, 8'h05, 8'h00},
    {1'b0, 1'b1, 2'd1, 8'h11, 8'h00},
    {1'b0, 1'b1, 2'd1, 8'h22, 8'h00},
    {1'b0, 1'b1, 2'd1, 8'h33, 8'h00},
    {1'b1, 1'b0, 2'd2, 8'h00, 8'h05},
    {1'b0, 1'b1, 2'd1, 8'h44, 8'h00},
    {1'b1, 1'b0, 2'd2, 8'h00, 8'h06},
    {1'b0, 1'b1, 2'd1, 8'h55, 8'h00},
    {1'b0, 1'b1, 2'd1, 8'h66, 8'h00},
    {1'b0, 1'b1, 2'd1, 8'h77, 8'h00},
    {1'b0, 1'b1, 2'd1, 8'h88, 8'h00},
    {1'b0, 1'b1, 2'd2, 8'h05, 8'h00},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h11},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h22},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h33},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h44},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h55},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h66},
    {1'b1, 1'b0, 2'd2, 8'h00, 8'h06},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h77},
    {1'b0, 1'b1, 2'd2, 8'h05, 8'h00},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h11},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'h22}
  };

  task automatic acc(input logic w, input logic [1:0] r, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    hst_sel = 1; hst_wr = w; hst_reg = r; hst_wdata = d;
    #3 q = hst_rdata;
    @(posedge clk);
    #1 hst_sel = 0; hst_wr = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] r, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b1, r, d, q);
  endtask

  task automatic rd_chk(input logic [1:0] r, input logic [7:0] exp, input string tag);
    logic [7:0] q;
    acc(1'b0, r, 8'h00, q);
    chk(tag, q, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 outputs", {5'b0, step_o, seq_rst_o, load_en_o}, 8'h00);
    rd_chk(2'd0, 8'h00, "R1 ctl");
    rd_chk(2'd2, 8'h00, "R1 addr lo");
    rd_chk(2'd3, 8'h00, "R1 addr hi");
    // R2 control bits
    wr(2'd0, 8'h05);
    rd_chk(2'd0, 8'h05, "R2 ctl readback");
    chk("R2 outputs", {5'b0, step_o, seq_rst_o, load_en_o}, 8'h05);
    // R3 R5 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] q;
      acc(VEC[i][18], VEC[i][17:16], VEC[i][15:8], q);
      if (VEC[i][19]) chk($sformatf("R3/R5/R7 vec %0d", i), q, VEC[i][7:0]);
    end
    // R8 load disabled
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h05);
    for (int i = 0; i < 4; i++) wr(2'd1, 8'hAA);
    rd_chk(2'd1, 8'h00, "R8 read zero");
    rd_chk(2'd2, 8'h05, "R8 addr unchanged");
    wr(2'd0, 8'h01);
    rd_chk(2'd1, 8'h11, "R8 ram unchanged");
    rd_chk(2'd1, 8'h22, "R8 lane unchanged");
    // R4 upper address bit, R9 wrap
    wr(2'd3, 8'hFF);
    rd_chk(2'd3, 8'h01, "R4 addr hi one bit");
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hDE); wr(2'd1, 8'hAD); wr(2'd1, 8'hBE); wr(2'd1, 8'hEF);
    rd_chk(2'd2, 8'h00, "R9 wrap lo");
    rd_chk(2'd3, 8'h00, "R9 wrap hi");
    wr(2'd3, 8'h01); wr(2'd2, 8'hFF);
    rd_chk(2'd1, 8'hDE, "R7 lane0");
    rd_chk(2'd1, 8'hAD, "R7 lane1");
    rd_chk(2'd1, 8'hBE, "R7 lane2");
    rd_chk(2'd1, 8'hEF, "R7 lane3");
    rd_chk(2'd3, 8'h00, "R9 read wrap");
    // R6 control reset
    wr(2'd2, 8'h33);
    wr(2'd1, 8'h01); wr(2'd1, 8'h02);
    wr(2'd0, 8'h03);
    rd_chk(2'd2, 8'h00, "R6 addr cleared");
    chk("R6 seq_rst_o", {7'b0, seq_rst_o}, 8'h01);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03); wr(2'd1, 8'h04);
    rd_chk(2'd2, 8'h00, "R6 lane cleared");
    wr(2'd1, 8'h05); wr(2'd1, 8'h06);
    rd_chk(2'd2, 8'h01, "R6 commit after four");
    wr(2'd2, 8'h00);
    rd_chk(2'd1, 8'h03, "R3 lsb first");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule